// File: doc/BRIEF.md
# Parallel NOR Flash Host Bus Front-End

This block sits at the host-facing pins of an asynchronous parallel NOR flash and turns them into synchronous events for the core behind it. A fast internal clock samples the active-low chip, output and write enables. Each enable passes through a two-flop synchronizer. Chip and write enable then pass through a glitch filter. The block decodes read, write, output-disable and standby from the filtered levels.

On a read it places the sampled address on a read-address port. It drives the data bus from the read-data port, which stands in for the array. When the high-voltage identifier flag is set and address bit 1 is low, it returns an identifier code in place of array data. On a write it captures the address when the write opens: the second of chip enable and write enable to fall. It captures the data when the write closes: the first of the two to rise. Each completed write raises a one-cycle strobe for a downstream command interpreter. Writes during which output enable was low are discarded and reported as protocol violations.

A byte mode narrows the data path to the low eight lines. In this mode the top data line serves as an extra least-significant address bit.

Top module: `flash_bus_front`

## Requirements
- R1: With chip enable low, output enable low and write enable high, the block enables all 16 data lines (word mode). It drives them with `rd_data`, and `rd_addr` equals `{addr_in, 1'b0}`.
- R2: While output enable is high, `dq_oe` is all zero whatever the other pins do.
- R3: While chip enable is high, `dq_oe` is all zero whatever the other pins do.
- R4: A write captures `cmd_addr` from the address pins as they stand when the later of chip enable and write enable goes low. Later address changes do not affect it.
- R5: A write captures `cmd_data` from the data pins as they stand when the earlier of chip enable and write enable returns high. Data changes after that point do not affect it.
- R6: Each completed write with output enable high throughout produces `cmd_valid` high for exactly one clock.
- R7: A write during which output enable was low at any point produces a one-cycle `wr_violation` pulse and no `cmd_valid`.
- R8: A low pulse on write enable or chip enable that lasts fewer than `FILT_CYC` sample clocks is ignored. It causes neither `cmd_valid` nor `wr_violation`.
- R9: In byte mode (`byte_n` low), DQ15 is address bit A-1. It is the LSB of `rd_addr` (bit 0) on reads and of `cmd_addr` on writes. Only `dq_oe[7:0]` may be set, `dq_out[7:0]` carries `rd_data[7:0]`, and `cmd_data` is `{8'h00, DQ[7:0]}`.
- R10: A read with `id_hv` high, A1 low and A0 low returns the manufacturer code. This is 0020h in word mode and 20h on DQ[7:0] in byte mode.
- R11: A read with `id_hv` high, A1 low and A0 high returns the device code. This is 22C4h / C4h when `TOP_BOOT`=1 and 2249h / 49h otherwise. With A1 high, array data is returned.
- R12: During and after reset, `dq_oe` is zero, `cmd_valid` and `wr_violation` are low, and `cmd_addr` and `cmd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| byte_n | input | 1 | Data width select: low = byte, high = word |
| id_hv | input | 1 | High-voltage flag on address bit 9 |
| addr_in | input | ADDR_W | Address pins A[ADDR_W-1:0] |
| dq_in | input | 16 | Data pins as seen by the input buffers |
| dq_out | output | 16 | Data bus output values |
| dq_oe | output | 16 | Per-line output enable of the data bus |
| rd_addr | output | ADDR_W+1 | Read address to the array, {A, A-1} |
| rd_data | input | 16 | Array read data |
| cmd_valid | output | 1 | One-cycle strobe for a completed write |
| cmd_addr | output | ADDR_W+1 | Captured write address, {A, A-1} |
| cmd_data | output | 16 | Captured write data |
| wr_violation | output | 1 | One-cycle strobe for a discarded write |

## Verification
Random reads over both bus widths check the enable masks and the array data path. Random identifier reads cover the manufacturer code, the device code and the A1-high fall-through, so each decode branch can be told apart. Random writes are run in both modes. In byte mode DQ15 is randomized, which separates the A-1 path from a fixed address LSB. Directed writes move the address between the two falling edges and the data between the two rising edges. A wrong capture point then shows up as the other value. Further directed cases cover an output-enable dip inside a write and a one-sample write-enable pulse. Each of these must leave the command strobe count unchanged.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
  localparam int unsigned DQ_W = 16;
  localparam logic [15:0] MANUF_CODE = 16'h0020;
  localparam logic [15:0] DEV_TOP    = 16'h22C4;
  localparam logic [15:0] DEV_BOTTOM = 16'h2249;

  typedef enum logic [0:0] {
    WR_IDLE = 1'b0,
    WR_OPEN = 1'b1
  } wr_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/enable_filter.sv
module enable_filter #(
  parameter int unsigned FILT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  output logic pin_f
);
  localparam int unsigned CNT_W = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             filt_q, filt_n;

  always_comb begin
    cnt_n  = cnt_q;
    filt_n = filt_q;
    if (pin_s == filt_q) begin
      cnt_n = '0;
    end else if (cnt_q == CNT_LAST) begin
      filt_n = pin_s;
      cnt_n  = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_n;
      filt_q <= filt_n;
    end
  end

  assign pin_f = filt_q;

  // R8
  filt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(pin_s) == filt_q));
endmodule

// File: rtl/write_capture.sv
module write_capture
  import flash_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_f,
  input  logic              we_f,
  input  logic              oe_s,
  input  logic              wide_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DQ_W-1:0]   dq_s,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [DQ_W-1:0]   cmd_data,
  output logic              wr_violation
);
  wr_state_e         state_q, state_n;
  logic              bad_q, bad_n;
  logic              valid_q, valid_n;
  logic              viol_q, viol_n;
  logic [ADDR_W:0]   addr_q, addr_n;
  logic [DQ_W-1:0]   data_q, data_n;
  logic              wr_on;

  assign wr_on = !ce_f && !we_f;

  always_comb begin
    state_n = state_q;
    bad_n   = bad_q;
    addr_n  = addr_q;
    data_n  = data_q;
    valid_n = 1'b0;
    viol_n  = 1'b0;
    case (state_q)
      WR_IDLE: begin
        if (wr_on) begin
          state_n = WR_OPEN;
          addr_n  = {addr_s, wide_s ? 1'b0 : dq_s[DQ_W-1]};
          bad_n   = !oe_s;
        end
      end
      WR_OPEN: begin
        if (!oe_s) bad_n = 1'b1;
        if (!wr_on) begin
          state_n = WR_IDLE;
          if (bad_q || !oe_s) begin
            viol_n = 1'b1;
          end else begin
            valid_n = 1'b1;
            data_n  = wide_s ? dq_s : {8'h00, dq_s[7:0]};
          end
        end
      end
      default: state_n = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      bad_q   <= 1'b0;
      valid_q <= 1'b0;
      viol_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_n;
      bad_q   <= bad_n;
      valid_q <= valid_n;
      viol_q  <= viol_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
    end
  end

  assign cmd_valid    = valid_q;
  assign wr_violation = viol_q;
  assign cmd_addr     = addr_q;
  assign cmd_data     = data_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && viol_q));
  // R7
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_q) |-> ($past(bad_q) || !$past(oe_s)));
endmodule

// File: rtl/read_path.sv
module read_path
  import flash_bus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter bit          TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_f,
  input  logic              we_f,
  input  logic              oe_s,
  input  logic              wide_s,
  input  logic              id_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic              dq15_s,
  input  logic [DQ_W-1:0]   rd_data,
  output logic [ADDR_W:0]   rd_addr,
  output logic [DQ_W-1:0]   dq_out,
  output logic [DQ_W-1:0]   dq_oe
);
  localparam logic [15:0] DEV_CODE = TOP_BOOT ? DEV_TOP : DEV_BOTTOM;

  logic            rd_act;
  logic            id_sel;
  logic [DQ_W-1:0] word_val;
  logic [DQ_W-1:0] out_n, oe_n;
  logic [DQ_W-1:0] out_q, oe_q;

  assign rd_act  = !ce_f && !oe_s && we_f;
  assign id_sel  = id_s && !addr_s[1];
  assign rd_addr = {addr_s, wide_s ? 1'b0 : dq15_s};

  always_comb begin
    if (id_sel) word_val = addr_s[0] ? DEV_CODE : MANUF_CODE;
    else        word_val = rd_data;
    out_n = '0;
    oe_n  = '0;
    if (rd_act) begin
      if (wide_s) begin
        out_n = word_val;
        oe_n  = '1;
      end else begin
        out_n = {8'h00, word_val[7:0]};
        oe_n  = {8'h00, 8'hFF};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= out_n;
      oe_q  <= oe_n;
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = oe_q;

  // R9
  byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|oe_q[15:8]) |-> $past(wide_s));
  // R2
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|oe_q) |-> !$past(oe_s));
  // R3
  ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|oe_q) |-> !$past(ce_f));
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_bus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned FILT_CYC = 2,
  parameter int unsigned SYNC_STG = 2,
  parameter bit          TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              byte_n,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe,
  output logic [ADDR_W:0]   rd_addr,
  input  logic [15:0]       rd_data,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [15:0]       cmd_data,
  output logic              wr_violation
);
  localparam int unsigned CTL_W  = 5;
  localparam int unsigned BUS_W  = CTL_W + ADDR_W + DQ_W;
  localparam logic [BUS_W-1:0] SYNC_RST = {5'b11110, {(ADDR_W + DQ_W){1'b0}}};

  logic [BUS_W-1:0]  raw_bus, sync_bus;
  logic              ce_s, oe_s, we_s, wide_s, id_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DQ_W-1:0]   dq_s;
  logic              ce_f, we_f;

  assign raw_bus = {ce_n, oe_n, we_n, byte_n, id_hv, addr_in, dq_in};

  pin_sync #(.W(BUS_W), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign {ce_s, oe_s, we_s, wide_s, id_s, addr_s, dq_s} = sync_bus;

  enable_filter #(.FILT_CYC(FILT_CYC)) i_ce_filt (
    .clk(clk), .rst_n(rst_n), .pin_s(ce_s), .pin_f(ce_f)
  );

  enable_filter #(.FILT_CYC(FILT_CYC)) i_we_filt (
    .clk(clk), .rst_n(rst_n), .pin_s(we_s), .pin_f(we_f)
  );

  write_capture #(.ADDR_W(ADDR_W)) i_wcap (
    .clk(clk), .rst_n(rst_n), .ce_f(ce_f), .we_f(we_f), .oe_s(oe_s),
    .wide_s(wide_s), .addr_s(addr_s), .dq_s(dq_s),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .wr_violation(wr_violation)
  );

  read_path #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) i_rpath (
    .clk(clk), .rst_n(rst_n), .ce_f(ce_f), .we_f(we_f), .oe_s(oe_s),
    .wide_s(wide_s), .id_s(id_s), .addr_s(addr_s), .dq15_s(dq_s[DQ_W-1]),
    .rd_data(rd_data), .rd_addr(rd_addr), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (dq_oe == '0 && !cmd_valid && !wr_violation) || !rst_n);
endmodule

// File: tb/test_flash_bus_front.sv
`timescale 1ns/1ps
module test_flash_bus_front;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, byte_n, id_hv;
  logic [AW-1:0] addr_in;
  logic [15:0]   dq_in, dq_out, dq_oe, rd_data, cmd_data;
  logic [AW:0]   rd_addr, cmd_addr;
  logic          cmd_valid, wr_violation;

  int n_chk = 0, n_fail = 0, n_valid = 0, n_viol = 0;
  logic [AW:0] last_addr;
  logic [15:0] last_data;

  always #2 clk = ~clk;

  function automatic logic [15:0] arr(input logic [AW:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C ^ {11'b0, a[20:16]};
  endfunction

  assign rd_data = arr(rd_addr);

  flash_bus_front #(.ADDR_W(AW)) i_flash_bus_front (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .byte_n(byte_n), .id_hv(id_hv), .addr_in(addr_in), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .wr_violation(wr_violation)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_valid++;
      last_addr = cmd_addr;
      last_data = cmd_data;
    end
    if (wr_violation) n_viol++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_word(input logic [AW-1:0] a, input logic id, input logic am1, input logic wide);
    logic [15:0] w;
    if (id && !a[1]) w = a[0] ? 16'h22C4 : 16'h0020;
    else             w = arr({a, wide ? 1'b0 : am1});
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  task automatic do_read(input string req, input logic [AW-1:0] a, input logic id, input logic am1, input logic wide);
    addr_in = a; id_hv = id; byte_n = wide; dq_in = {am1, 15'h0};
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    cyc(8);
    check(req, dq_oe, wide ? 16'hFFFF : 16'h00FF);
    check(req, dq_out, exp_word(a, id, am1, wide));
    check(req, rd_addr, {a, wide ? 1'b0 : am1});
    oe_n = 1'b1; ce_n = 1'b1;
    cyc(8);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic wide);
    addr_in = a; dq_in = d; byte_n = wide; id_hv = 1'b0;
    oe_n = 1'b1; ce_n = 1'b0;
    cyc(3);
    we_n = 1'b0; cyc(6);
    we_n = 1'b1; cyc(6);
    ce_n = 1'b1; cyc(8);
  endtask

  initial begin
    #(4ns * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int vb, va;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; byte_n = 1'b1;
    id_hv = 1'b0; addr_in = '0; dq_in = '0;
    cyc(4);
    // R12 reset state
    check("R12", {dq_oe, 12'h0, cmd_valid, wr_violation, 2'b0}, 32'h0);
    check("R12", {cmd_addr, cmd_data}, 37'h0);
    rst_n = 1'b1;
    cyc(4);

    // R1 directed word read
    do_read("R1", 20'hABCDE, 1'b0, 1'b0, 1'b1);
    // R2 output disable with chip enabled
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; cyc(8);
    check("R2", dq_oe, 16'h0);
    ce_n = 1'b1; cyc(4);
    // R3 standby with output enable low
    ce_n = 1'b1; oe_n = 1'b0; cyc(8);
    check("R3", dq_oe, 16'h0);
    oe_n = 1'b1; cyc(4);
    // R10 / R11 identifier reads
    do_read("R10", 20'h00200, 1'b1, 1'b0, 1'b1);
    do_read("R10", 20'h00200, 1'b1, 1'b1, 1'b0);
    do_read("R11", 20'h00201, 1'b1, 1'b0, 1'b1);
    do_read("R11", 20'h00201, 1'b1, 1'b0, 1'b0);
    do_read("R11", 20'h00203, 1'b1, 1'b0, 1'b1);
    // R9 byte read with A-1 high
    do_read("R9", 20'h12345, 1'b0, 1'b1, 1'b0);

    // random reads
    for (int i = 0; i < 60; i++) begin
      vb = $urandom;
      do_read(vb[0] ? "R1" : "R9", 20'($urandom), vb[1] & vb[2], vb[3], vb[0]);
    end

    // random writes
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      logic [15:0] d;
      logic wide;
      va = n_valid;
      a = 20'($urandom); d = 16'($urandom); vb = $urandom; wide = vb[0];
      do_write(a, d, wide);
      check("R6", n_valid, va + 1);
      check(wide ? "R4" : "R9", last_addr, {a, wide ? 1'b0 : d[15]});
      check(wide ? "R5" : "R9", last_data, wide ? d : {8'h00, d[7:0]});
    end

    // R4 address taken at later falling edge (we after ce)
    va = n_valid;
    byte_n = 1'b1; oe_n = 1'b1; addr_in = 20'h11111; dq_in = 16'h3C3C;
    ce_n = 1'b0; cyc(3);
    addr_in = 20'h22222; cyc(3);
    we_n = 1'b0; cyc(8);
    addr_in = 20'h33333; cyc(3);
    we_n = 1'b1; cyc(6); ce_n = 1'b1; cyc(8);
    check("R4", last_addr, {20'h22222, 1'b0});
    check("R6", n_valid, va + 1);

    // R4 / R5: ce falls last, ce rises first; data changes after ce rise
    addr_in = 20'h44444; dq_in = 16'hAAAA;
    we_n = 1'b0; cyc(3);
    addr_in = 20'h55555; cyc(3);
    ce_n = 1'b0; cyc(8);
    addr_in = 20'h66666; dq_in = 16'hBEEF; cyc(3);
    ce_n = 1'b1; cyc(8);
    dq_in = 16'h1234; cyc(3);
    we_n = 1'b1; cyc(8);
    check("R4", last_addr, {20'h55555, 1'b0});
    check("R5", last_data, 16'hBEEF);

    // R7 output enable dip during a write
    va = n_valid; vb = n_viol;
    ce_n = 1'b0; cyc(3); we_n = 1'b0; cyc(4);
    oe_n = 1'b0; cyc(3); oe_n = 1'b1; cyc(3);
    we_n = 1'b1; cyc(6); ce_n = 1'b1; cyc(8);
    check("R7", n_viol, vb + 1);
    check("R7", n_valid, va);

    // R8 short write-enable pulse ignored
    va = n_valid; vb = n_viol;
    ce_n = 1'b0; cyc(4);
    we_n = 1'b0; #4; we_n = 1'b1;
    cyc(10); ce_n = 1'b1; cyc(8);
    check("R8", n_valid, va);
    check("R8", n_viol, vb);
    // R8 short chip-enable pulse ignored
    we_n = 1'b0; cyc(4);
    ce_n = 1'b0; #4; ce_n = 1'b1;
    cyc(10); we_n = 1'b1; cyc(8);
    check("R8", n_valid, va);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule